// File: doc/BRIEF.md
# Feed-Protected Clock Synthesizer Settings Block

This block holds the settings for an on-chip clock synthesizer and guards them against stray writes. Software writes the control word (enable and connect) and the configuration word (multiplier and post-divider) over a simple register bus. Those writes only update holding copies. The values that drive the synthesizer live in shadow registers. The shadows are loaded from both holding copies at once, and only when a two-write unlock key arrives at a dedicated write-only key register.

A read-only status word shows the shadow values that are actually in effect, together with the lock indication from the synthesizer. A staged write that has not yet been committed never shows up in status.

The intended software flow has three steps. First, program and commit with enable set. Second, poll status until lock is seen. Third, set connect and commit again. The connect output is gated by enable and by lock, so losing lock falls back to the bypass clock at once. Reset and the power-down input both leave the synthesizer disabled and bypassed.

Top module: `pll_cfg_regs`

## Requirements
- R1: After synchronous reset, syn_enable, syn_connect, syn_mult_code and syn_div_sel are all zero, and the status word reads zero.
- R2: A write to the control word (word 0: bit 0 enable, bit 1 connect) or to the configuration word (word 1: bits 4:0 multiplier code, bits 6:5 divider code) is read back from that word, but it does not change any synthesizer output or the status word.
- R3: A write of 0xAA to the key word (word 3, low byte), followed by a write of 0x55 as the next bus access, copies both holding words into the shadows. The outputs show the new values one clock after the 0x55 write.
- R4: Any other bus access (a read or a write to any word) between the 0xAA and the 0x55 aborts the unlock, so the shadows stay unchanged. Idle cycles with no access do not abort it.
- R5: A key write with a value other than 0x55 after 0xAA aborts the unlock. A new 0xAA always re-arms it, so the sequence 0xAA, 0xAA, 0x55 loads the shadows.
- R6: The status word (word 2) reads as follows: bits 4:0 give the shadow multiplier code, bits 6:5 the shadow divider code, bit 8 the shadow enable, bit 9 the shadow connect, bit 10 the live lock input, and all other bits are zero.
- R7: syn_connect is high exactly when the shadow enable, the shadow connect and lock_in are all high.
- R8: While pdown is high, the shadow enable and connect are cleared one clock later and the unlock cannot load the shadows. After pdown falls, only a new unlock enables the synthesizer again.
- R9: The multiplier m in 1..32 is held as code m-1 in 5 bits. Divider codes 0, 1, 2 and 3 select divide by 2, 4, 8 and 16, which is 2 shifted left by the code.
- R10: Reads of the key word return zero, and writes to the status word have no effect on status or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| pdown | input | 1 | Power-down request, level sensitive |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| lock_in | input | 1 | Lock indication from the synthesizer |
| syn_enable | output | 1 | Synthesizer enable (shadow) |
| syn_connect | output | 1 | Use the synthesizer output as the system clock |
| syn_mult_code | output | 5 | Multiplier minus one (shadow) |
| syn_div_sel | output | 2 | Post-divider code (shadow) |

## Verification
The configuration path is swept over all 32 multipliers and all 4 divider codes. Each commit is checked at the outputs and in status, and before each commit the bench confirms that the staged value had not leaked out. The control path is tried with every enable/connect pair against both lock levels, which separates the gating of connect from the stored bits. The unlock is then driven with interleaved reads and writes, idle gaps, a wrong second key and a doubled first key, which shows what aborts the sequence and what does not. Power-down is applied with the synthesizer connected and again during an unlock attempt.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int NREG      = 4;
    localparam int MULT_W    = 5;
    localparam int DIV_W     = 2;
    localparam int KEY_W     = 8;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'h55;

    // Status bit positions.
    localparam int ST_EN_BIT   = 8;
    localparam int ST_CON_BIT  = 9;
    localparam int ST_LOCK_BIT = 10;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_STAT = 2'd2,
        REG_KEY  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic con;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [MULT_W-1:0] mult;
    } cfg_t;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.en  = w[0];
        c.con = w[1];
        return c;
    endfunction

    function automatic cfg_t word_to_cfg(input logic [31:0] w);
        cfg_t c;
        c.mult = w[MULT_W-1:0];
        c.div  = w[MULT_W+DIV_W-1:MULT_W];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w    = '0;
        w[0] = c.en;
        w[1] = c.con;
        return w;
    endfunction

    function automatic logic [31:0] cfg_to_word(input cfg_t c);
        logic [31:0] w;
        w = '0;
        w[MULT_W+DIV_W-1:0] = c;
        return w;
    endfunction

    function automatic logic [31:0] status_word(input ctrl_t c, input cfg_t f,
                                                input logic lock);
        logic [31:0] w;
        w = cfg_to_word(f);
        w[ST_EN_BIT]   = c.en;
        w[ST_CON_BIT]  = c.con;
        w[ST_LOCK_BIT] = lock;
        return w;
    endfunction

endpackage

// File: rtl/pll_bus_decode.sv
module pll_bus_decode
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_idx_e          idx,
    output logic [NREG-1:0]   wr_hit
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + $clog2(NREG) - 1;

    assign idx = reg_idx_e'(bus_addr[IDX_HI:IDX_LO]);

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g] = bus_sel && bus_wr && (idx == reg_idx_e'(g));
    end

    logic unused_addr;
    assign unused_addr = ^{bus_addr[ADDR_W-1:IDX_HI], bus_addr[IDX_LO-1:0]};

endmodule

// File: rtl/pll_key_seq.sv
module pll_key_seq
    import pll_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pdown,
    input  logic             access,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    output logic             load
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (pdown) begin
            state_d = KEY_IDLE;
        end else if (access) begin
            state_d = (key_wr && key == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
        end
    end

    assign load = (state_q == KEY_ARMED) && access && key_wr &&
                  (key == KEY_SECOND) && !pdown;

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pll_shadow_regs.sv
module pll_shadow_regs
    import pll_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pdown,
    input  logic        wr_ctrl,
    input  logic        wr_cfg,
    input  logic [31:0] wdata,
    input  logic        load,
    output ctrl_t       hold_ctrl,
    output cfg_t        hold_cfg,
    output ctrl_t       shd_ctrl,
    output cfg_t        shd_cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_ctrl <= '0;
            hold_cfg  <= '0;
        end else begin
            if (wr_ctrl) hold_ctrl <= word_to_ctrl(wdata);
            if (wr_cfg)  hold_cfg  <= word_to_cfg(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_ctrl <= '0;
            shd_cfg  <= '0;
        end else if (pdown) begin
            shd_ctrl <= '0;
        end else if (load) begin
            shd_ctrl <= hold_ctrl;
            shd_cfg  <= hold_cfg;
        end
    end

endmodule

// File: rtl/pll_status_gen.sv
module pll_status_gen
    import pll_cfg_pkg::*;
(
    input  ctrl_t       shd_ctrl,
    input  cfg_t        shd_cfg,
    input  logic        lock_in,
    output logic        connect,
    output logic [31:0] status
);

    assign connect = shd_ctrl.en && shd_ctrl.con && lock_in;
    assign status  = status_word(shd_ctrl, shd_cfg, lock_in);

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pdown,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock_in,
    output logic              syn_enable,
    output logic              syn_connect,
    output logic [MULT_W-1:0] syn_mult_code,
    output logic [DIV_W-1:0]  syn_div_sel
);

    reg_idx_e        idx;
    logic [NREG-1:0] wr_hit;
    logic            load;
    ctrl_t           hold_ctrl, shd_ctrl;
    cfg_t            hold_cfg, shd_cfg;
    logic [31:0]     status;
    logic [31:0]     wdata32;

    assign wdata32 = 32'(bus_wdata);

    pll_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .idx      (idx),
        .wr_hit   (wr_hit)
    );

    pll_key_seq u_key (
        .clk    (clk),
        .rst    (rst),
        .pdown  (pdown),
        .access (bus_sel),
        .key_wr (wr_hit[REG_KEY]),
        .key    (wdata32[KEY_W-1:0]),
        .load   (load)
    );

    pll_shadow_regs u_shd (
        .clk       (clk),
        .rst       (rst),
        .pdown     (pdown),
        .wr_ctrl   (wr_hit[REG_CTRL]),
        .wr_cfg    (wr_hit[REG_CFG]),
        .wdata     (wdata32),
        .load      (load),
        .hold_ctrl (hold_ctrl),
        .hold_cfg  (hold_cfg),
        .shd_ctrl  (shd_ctrl),
        .shd_cfg   (shd_cfg)
    );

    pll_status_gen u_st (
        .shd_ctrl (shd_ctrl),
        .shd_cfg  (shd_cfg),
        .lock_in  (lock_in),
        .connect  (syn_connect),
        .status   (status)
    );

    always_comb begin
        logic [31:0] r;
        unique case (idx)
            REG_CTRL: r = ctrl_to_word(hold_ctrl);
            REG_CFG:  r = cfg_to_word(hold_cfg);
            REG_STAT: r = status;
            default:  r = '0;
        endcase
        bus_rdata = DATA_W'(r);
    end

    assign syn_enable    = shd_ctrl.en;
    assign syn_mult_code = shd_cfg.mult;
    assign syn_div_sel   = shd_cfg.div;

    // Status writes are decoded and deliberately dropped.
    logic unused_wr;
    assign unused_wr = wr_hit[REG_STAT] ^ (^wdata32[31:KEY_W]);

endmodule

// File: rtl/pll_cfg_regs_chk.sv
module pll_cfg_regs_chk
    import pll_cfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pdown,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              lock_in,
    input logic              syn_enable,
    input logic              syn_connect,
    input logic [MULT_W-1:0] syn_mult_code,
    input logic [DIV_W-1:0]  syn_div_sel
);

    logic key2_wr, stat_rd, key_rd;
    assign key2_wr = bus_sel && bus_wr && bus_addr[3:2] == 2'd3 &&
                     bus_wdata[7:0] == KEY_SECOND;
    assign stat_rd = bus_sel && !bus_wr && bus_addr[3:2] == 2'd2;
    assign key_rd  = bus_sel && !bus_wr && bus_addr[3:2] == 2'd3;

    // R3: settings change only right after a second key write
    a_r3_cfg_needs_key: assert property (@(posedge clk) disable iff (rst)
        !$stable({syn_mult_code, syn_div_sel}) |-> $past(key2_wr));

    // R3: enable can rise only right after a second key write
    a_r3_enable_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(syn_enable) |-> $past(key2_wr));

    // R7
    a_r7_connect_gated: assert property (@(posedge clk) disable iff (rst)
        syn_connect |-> (syn_enable && lock_in));

    // R8
    a_r8_pdown_disables: assert property (@(posedge clk) disable iff (rst)
        pdown |=> !syn_enable);

    // R6
    a_r6_status_live: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (bus_rdata[6:0] == {syn_div_sel, syn_mult_code} &&
                     bus_rdata[ST_EN_BIT] == syn_enable &&
                     bus_rdata[ST_LOCK_BIT] == lock_in));

    // R10
    a_r10_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
        key_rd |-> bus_rdata == '0);

endmodule

bind pll_cfg_regs pll_cfg_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pdown         (pdown),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .lock_in       (lock_in),
    .syn_enable    (syn_enable),
    .syn_connect   (syn_connect),
    .syn_mult_code (syn_mult_code),
    .syn_div_sel   (syn_div_sel)
);

// File: tb/pll_cfg_regs_tb.sv
module pll_cfg_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pdown = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lock_in = 1'b0;
    logic        syn_enable, syn_connect;
    logic [4:0]  syn_mult_code;
    logic [1:0]  syn_div_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_STAT = 4'h8, A_KEY = 4'hC;

    always #5 clk = ~clk;

    pll_cfg_regs u_dut (
        .clk(clk), .rst(rst), .pdown(pdown), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_in(lock_in), .syn_enable(syn_enable), .syn_connect(syn_connect),
        .syn_mult_code(syn_mult_code), .syn_div_sel(syn_div_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic unlock();
        wr(A_KEY, 32'hAA);
        wr(A_KEY, 32'h55);
    endtask

    function automatic logic [31:0] exp_status(input logic en, input logic con,
                                               input logic [4:0] m, input logic [1:0] d,
                                               input logic lk);
        return {21'd0, lk, con, en, 1'b0, d, m};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [4:0]  cur_m;
        logic [1:0]  cur_d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", {syn_enable, syn_connect, syn_mult_code, syn_div_sel}, 0);
        rd(A_STAT, r);
        check("R1 status", r, 0);

        // R9/R2/R3/R6 sweep over all multipliers and dividers
        lock_in = 1'b1;
        cur_m = 0; cur_d = 0;
        for (int m = 1; m <= 32; m++) begin
            for (int d = 0; d < 4; d++) begin
                logic [31:0] w;
                w = (32'(d) << 5) | 32'(m - 1);
                wr(A_CFG, w);
                check("R2 staged not live", {syn_mult_code, syn_div_sel}, {cur_m, cur_d});
                rd(A_CFG, r);
                check("R2 holding readback", r, w);
                unlock();
                cur_m = 5'(m - 1); cur_d = 2'(d);
                check("R9 mult code", syn_mult_code, 32'(m - 1));
                check("R9 div ratio", 32'(2) << syn_div_sel, 32'(1) << (d + 1));
                rd(A_STAT, r);
                check("R6 status", r, exp_status(0, 0, cur_m, cur_d, 1));
            end
        end

        // R7 connect gating, all control pairs against both lock levels
        for (int c = 0; c < 4; c++) begin
            for (int lk = 0; lk < 2; lk++) begin
                lock_in = 1'b0;
                wr(A_CTRL, 32'(c));
                unlock();
                lock_in = 1'(lk);
                #1;
                check("R7 enable", syn_enable, 32'(c & 1));
                check("R7 connect", syn_connect, 32'((c & 1) & (c >> 1) & lk));
                rd(A_STAT, r);
                check("R6 status ctrl", r, exp_status(1'(c & 1), 1'(c >> 1), cur_m, cur_d, 1'(lk)));
            end
        end

        // R2 control staged only
        lock_in = 1'b1;
        wr(A_CTRL, 0); unlock();
        wr(A_CTRL, 3);
        check("R2 ctrl staged", {syn_enable, syn_connect}, 0);
        rd(A_CTRL, r);
        check("R2 ctrl readback", r, 3);
        rd(A_STAT, r);
        check("R2 status unchanged", r, exp_status(0, 0, cur_m, cur_d, 1));

        // R4 aborts by a read and by another write; idle gap keeps it armed
        wr(A_KEY, 32'hAA); rd(A_CTRL, r); wr(A_KEY, 32'h55);
        check("R4 read aborts", syn_enable, 0);
        wr(A_KEY, 32'hAA); wr(A_CTRL, 3); wr(A_KEY, 32'h55);
        check("R4 write aborts", syn_enable, 0);
        wr(A_KEY, 32'hAA); repeat (4) @(negedge clk); wr(A_KEY, 32'h55);
        check("R4 idle keeps armed", {syn_enable, syn_connect}, 3);

        // R5 wrong second key, and re-arm
        wr(A_CTRL, 0);
        wr(A_KEY, 32'hAA); wr(A_KEY, 32'h56); wr(A_KEY, 32'h55);
        check("R5 wrong key aborts", syn_enable, 1);
        wr(A_KEY, 32'hAA); wr(A_KEY, 32'hAA); wr(A_KEY, 32'h55);
        check("R5 re-arm loads", syn_enable, 0);

        // R8 power-down
        wr(A_CTRL, 3); unlock();
        check("R8 pre", {syn_enable, syn_connect}, 3);
        @(negedge clk); pdown = 1'b1;
        @(negedge clk);
        check("R8 disabled", {syn_enable, syn_connect}, 0);
        unlock();
        check("R8 key ignored in pdown", syn_enable, 0);
        pdown = 1'b0;
        @(negedge clk);
        check("R8 stays off", syn_enable, 0);
        unlock();
        check("R8 re-enabled by key", {syn_enable, syn_connect}, 3);

        // R10 key reads zero, status writes ignored
        wr(A_KEY, 32'hAA);
        rd(A_KEY, r);
        check("R10 key read", r, 0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, r);
        check("R10 status write ignored", r, exp_status(1, 1, cur_m, cur_d, 1));
        check("R10 outputs kept", {syn_mult_code, syn_div_sel}, {cur_m, cur_d});

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule